// File: doc/BRIEF.md
# Indirect Translation Entry List Loader

This block fills a run of consecutive pages in an address translation table from a list of 64-bit entries held in system memory. A request gives a starting bus address, the physical address of the entry list, a page count, and a flag from an external lookup that says whether the addressed table exists. The loader validates the request and then loops over the list. For each entry it issues one read on a memory read master port, waits for the data, and writes the entry into the table through the table's single-entry write port at the next page-aligned bus address.

The loop stops at the first table write that returns a nonzero status. When the request finishes, the block pulses a completion strobe. The strobe carries a final status and the index of the last entry that succeeded, or of the first entry that failed.

Three interfaces carry data, and each one is valid/ready: the request input, the read request and read response pair, and the table write. A source that raises valid keeps valid and its payload unchanged until the cycle in which ready is also high. The loader's own ready outputs depend only on its state. Any stall by the memory or by the table simply stretches the loop.

Top module: `itl_list_loader`

## Requirements
- R1: A request whose page count is greater than MAX_ENTRIES (512) completes with status 1 (parameter error) and index 0, and makes no memory read. A count of exactly 512 is processed in full.
- R2: A request whose list address has any of its low LIST_SHIFT (12) bits set completes with status 1 and index 0, and makes no memory read.
- R3: A request with a page count of zero, or with the table-found flag low, completes with status 1 and index 0, and makes no memory read.
- R4: Entry i is read from the list address with its two low permission bits cleared, plus 8*i bytes. Reads are issued in increasing i.
- R5: Entry i is written to the table at the starting bus address aligned down to the page size (PAGE_SHIFT = 12), plus i pages. The write data is exactly the 64-bit word returned for read i.
- R6: At most one memory read is outstanding. No new read request is raised until the response to the previous one has been accepted.
- R7: If a table write returns a nonzero wr_status, the loop stops after that entry with no further reads or writes, and done_status equals that wr_status. Status 0 means success. A loop that completes reports status 0.
- R8: done_index is count-1 after full success. After a failure at entry k, it is k-1, or 0 when k is 0.
- R9: rd_req_valid with rd_req_addr, and wr_valid with wr_addr and wr_data, are held stable until their handshake.
- R10: done_valid is high for exactly one cycle. For a rejected request it comes the cycle after request acceptance; otherwise it comes the cycle after the final write handshake. req_ready is high only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_bus_addr | input | ADDR_W | Starting bus address (aligned down internally) |
| req_list_addr | input | ADDR_W | Physical address of the entry list |
| req_count | input | CNT_W | Number of pages to fill |
| req_table_found | input | 1 | External lookup found the addressed table |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Byte address of the entry to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Loader accepts read data |
| rd_rsp_data | input | DATA_W | Entry word read from memory |
| wr_valid | output | 1 | Table write valid |
| wr_ready | input | 1 | Table accepts the write |
| wr_addr | output | ADDR_W | Page-aligned bus address being written |
| wr_data | output | DATA_W | Entry value |
| wr_status | input | STAT_W | Table result for the accepted write, 0 = success |
| done_valid | output | 1 | One-cycle completion strobe |
| done_status | output | STAT_W | 0 success, 1 parameter error, else table code |
| done_index | output | IDX_W | Last successful or first failing entry index |

## Verification
A rejected request produces its result at the first clock edge after acceptance, so the bench expects the strobe one cycle after the acceptance cycle. An accepted request spends at least three cycles per entry (read request, read response, table write), because all of the loader's outputs are registered state. Its strobe is due one cycle after the last write handshake. The bench counts cycles on the rising edge, and records every handshake from the final values of valid and ready at the falling edge just before that edge. It compares the strobe cycle with the recorded handshake cycle, so stalls injected by the memory and table models move the expectation along with them.

// File: rtl/itl_pkg.sv
package itl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRITE,
    ST_DONE
  } itl_state_e;

  localparam logic [1:0] STAT_OK    = 2'd0;
  localparam logic [1:0] STAT_PARAM = 2'd1;
endpackage

// File: rtl/itl_req_check.sv
module itl_req_check #(
  parameter int ADDR_W      = 64,
  parameter int CNT_W       = 16,
  parameter int MAX_ENTRIES = 512,
  parameter int LIST_SHIFT  = 12
) (
  input  logic [ADDR_W-1:0] list_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              found,
  output logic              accept
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ENTRIES);

  logic count_ok;
  logic list_ok;

  always_comb begin
    count_ok = (count != '0) && (count <= MAX_CNT);
    list_ok  = (list_addr[LIST_SHIFT-1:0] == '0);
    accept   = found && count_ok && list_ok;
  end
endmodule

// File: rtl/itl_cursor.sv
module itl_cursor #(
  parameter int ADDR_W      = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int LOOP_W      = 10,
  parameter int PERM_BITS   = 2,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] bus_in,
  input  logic [ADDR_W-1:0] list_in,
  input  logic [LOOP_W-1:0] cnt_in,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LOOP_W-1:0] idx,
  output logic              last
);
  localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] PAGE_MASK  = ~(PAGE_BYTES - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] PERM_MASK  = ~((ADDR_W'(1) << PERM_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] base_q;
  logic [LOOP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      bus_addr <= '0;
      idx      <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      base_q   <= list_in & PERM_MASK;
      bus_addr <= bus_in & PAGE_MASK;
      idx      <= '0;
      cnt_q    <= cnt_in;
    end else if (step) begin
      bus_addr <= bus_addr + PAGE_BYTES;
      idx      <= idx + LOOP_W'(1);
    end
  end

  always_comb begin
    rd_addr = base_q + (ADDR_W'(idx) << ENTRY_SHIFT);
    last    = ((idx + LOOP_W'(1)) == cnt_q);
  end
endmodule

// File: rtl/itl_list_loader.sv
module itl_list_loader
  import itl_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int DATA_W      = 64,
  parameter int STAT_W      = 2,
  parameter int PAGE_SHIFT  = 12,
  parameter int LIST_SHIFT  = 12,
  parameter int MAX_ENTRIES = 512,
  parameter int CNT_W       = 16,
  parameter int PERM_BITS   = 2,
  parameter int IDX_W       = $clog2(MAX_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_bus_addr,
  input  logic [ADDR_W-1:0] req_list_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_table_found,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic [STAT_W-1:0] wr_status,
  output logic              done_valid,
  output logic [STAT_W-1:0] done_status,
  output logic [IDX_W-1:0]  done_index
);
  localparam int LOOP_W      = $clog2(MAX_ENTRIES + 1);
  localparam int ENTRY_SHIFT = $clog2(DATA_W / 8);

  itl_state_e        state_q;
  logic              req_ok;
  logic              load;
  logic              step;
  logic [LOOP_W-1:0] idx;
  logic              last;
  logic [ADDR_W-1:0] cur_rd_addr;
  logic [ADDR_W-1:0] cur_bus_addr;
  logic [DATA_W-1:0] entry_q;
  logic              wr_fire;
  logic              wr_fail;

  itl_req_check #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .MAX_ENTRIES(MAX_ENTRIES),
    .LIST_SHIFT (LIST_SHIFT)
  ) u_check (
    .list_addr(req_list_addr),
    .count    (req_count),
    .found    (req_table_found),
    .accept   (req_ok)
  );

  itl_cursor #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .LOOP_W     (LOOP_W),
    .PERM_BITS  (PERM_BITS),
    .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .bus_in  (req_bus_addr),
    .list_in (req_list_addr),
    .cnt_in  (req_count[LOOP_W-1:0]),
    .rd_addr (cur_rd_addr),
    .bus_addr(cur_bus_addr),
    .idx     (idx),
    .last    (last)
  );

  always_comb begin
    req_ready    = (state_q == ST_IDLE);
    rd_req_valid = (state_q == ST_RDREQ);
    rd_rsp_ready = (state_q == ST_RDWAIT);
    wr_valid     = (state_q == ST_WRITE);
    done_valid   = (state_q == ST_DONE);
    rd_req_addr  = cur_rd_addr;
    wr_addr      = cur_bus_addr;
    wr_data      = entry_q;
    load         = req_ready && req_valid && req_ok;
    wr_fire      = wr_valid && wr_ready;
    wr_fail      = wr_fire && (wr_status != '0);
    step         = wr_fire && !wr_fail && !last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      entry_q     <= '0;
      done_status <= '0;
      done_index  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_ok) begin
              state_q <= ST_RDREQ;
            end else begin
              done_status <= STAT_W'(STAT_PARAM);
              done_index  <= '0;
              state_q     <= ST_DONE;
            end
          end
        end
        ST_RDREQ: begin
          if (rd_req_ready) state_q <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          if (rd_rsp_valid) begin
            entry_q <= rd_rsp_data;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_fail) begin
            done_status <= wr_status;
            done_index  <= (idx == '0) ? '0 : IDX_W'(idx - LOOP_W'(1));
            state_q     <= ST_DONE;
          end else if (wr_fire) begin
            if (last) begin
              done_status <= STAT_W'(STAT_OK);
              done_index  <= IDX_W'(idx);
              state_q     <= ST_DONE;
            end else begin
              state_q <= ST_RDREQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/itl_list_loader_chk.sv
module itl_list_loader_chk #(
  parameter int ADDR_W      = 64,
  parameter int DATA_W      = 64,
  parameter int STAT_W      = 2,
  parameter int PAGE_SHIFT  = 12,
  parameter int MAX_ENTRIES = 512,
  parameter int CNT_W       = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CNT_W-1:0]  req_count,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [STAT_W-1:0] wr_status,
  input logic              done_valid,
  input logic [STAT_W-1:0] done_status
);
  logic [1:0] outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= '0;
    else outstanding <= outstanding + 2'((rd_req_valid && rd_req_ready) ? 1 : 0)
                                    - 2'((rd_rsp_valid && rd_rsp_ready) ? 1 : 0);
  end

  a_r1_reject_large: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_count > CNT_W'(MAX_ENTRIES)))
      |=> (done_valid && (done_status == STAT_W'(1)) && !rd_req_valid));

  a_r4_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[2:0] == 3'd0));

  a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[PAGE_SHIFT-1:0] == '0));

  a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (outstanding == 2'd0));

  a_r7_error_return: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (wr_status != '0))
      |=> (done_valid && (done_status == $past(wr_status))));

  a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r9_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rd_req_valid, rd_rsp_ready, wr_valid, done_valid}));
endmodule

bind itl_list_loader itl_list_loader_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STAT_W     (STAT_W),
  .PAGE_SHIFT (PAGE_SHIFT),
  .MAX_ENTRIES(MAX_ENTRIES),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_count   (req_count),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid),
  .rd_rsp_ready(rd_rsp_ready),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .wr_status   (wr_status),
  .done_valid  (done_valid),
  .done_status (done_status)
);

// File: tb/test_itl_list_loader.sv
module test_itl_list_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_bus_addr = '0;
  logic [63:0] req_list_addr = '0;
  logic [15:0] req_count = '0;
  logic        req_table_found = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [63:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [63:0] rd_rsp_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [63:0] wr_addr;
  logic [63:0] wr_data;
  logic [1:0]  wr_status = '0;
  logic        done_valid;
  logic [1:0]  done_status;
  logic [8:0]  done_index;

  always #5 clk = ~clk;

  itl_list_loader i_itl_list_loader (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bus_addr(req_bus_addr), .req_list_addr(req_list_addr),
    .req_count(req_count), .req_table_found(req_table_found),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_status(wr_status),
    .done_valid(done_valid), .done_status(done_status), .done_index(done_index)
  );

  int nchecks = 0;
  int nerr = 0;
  int cyc = 0;
  int n_rd = 0;
  int n_wr = 0;
  int viol = 0;
  int fail_at = -1;
  logic [1:0] fail_code = 2'd0;
  int last_wr_cyc = 0;
  logic [63:0] rd_log [0:599];
  logic [63:0] wa_log [0:599];
  logic [63:0] wd_log [0:599];
  bit   pending = 0;
  int   lat = 0;
  logic [63:0] pend_addr = '0;
  bit   rd_hs_next = 0;
  bit   rsp_hs_next = 0;

  int   acc_cyc, done_cyc;
  logic [1:0] got_status;
  logic [8:0] got_index;
  bit   timed_out;

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {a[31:0] ^ 32'h5EED_1234, ~a[31:0] + 32'h0000_0003};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory responder and table model; all handshakes judged at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_req_ready = 0; rd_rsp_valid = 0; wr_ready = 0; wr_status = 0;
      pending = 0; rd_hs_next = 0; rsp_hs_next = 0;
    end else begin
      if (rd_hs_next) begin pending = 1; lat = n_rd % 3; end
      if (rsp_hs_next) rd_rsp_valid = 0;
      rd_req_ready = (cyc % 4) != 2;
      if (pending && !rd_rsp_valid) begin
        if (lat == 0) begin
          rd_rsp_valid = 1; rd_rsp_data = mem_word(pend_addr); pending = 0;
        end else lat--;
      end
      wr_ready  = (cyc % 3) != 1;
      wr_status = (n_wr == fail_at) ? fail_code : 2'd0;
      if (rd_req_valid && (pending || rd_rsp_valid)) viol++;
      rd_hs_next = rd_req_valid && rd_req_ready;
      if (rd_hs_next) begin
        if (n_rd < 600) rd_log[n_rd] = rd_req_addr;
        pend_addr = rd_req_addr;
        n_rd++;
      end
      rsp_hs_next = rd_rsp_valid && rd_rsp_ready;
      if (wr_valid && wr_ready) begin
        if (n_wr < 600) begin wa_log[n_wr] = wr_addr; wd_log[n_wr] = wr_data; end
        n_wr++;
        last_wr_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [63:0] bus, input logic [63:0] list,
                         input logic [15:0] cnt, input bit found,
                         input int f_at, input logic [1:0] f_code);
    int t;
    n_rd = 0; n_wr = 0; viol = 0; fail_at = f_at; fail_code = f_code;
    @(negedge clk);
    req_bus_addr = bus; req_list_addr = list; req_count = cnt;
    req_table_found = found; req_valid = 1;
    while (!req_ready) @(negedge clk);
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (!done_valid && t < 5000) begin @(negedge clk); t++; end
    timed_out = !done_valid;
    done_cyc = cyc; got_status = done_status; got_index = done_index;
    if (timed_out) chk(0, "timeout", 0, 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R10 reset req_ready", 64'(req_ready), 1);
    chk(done_valid === 1'b0 && rd_req_valid === 1'b0 && wr_valid === 1'b0,
        "R10 reset outputs idle", 64'({done_valid, rd_req_valid, wr_valid}), 0);
  endtask

  task automatic t_reject(input string tag, input logic [63:0] list,
                          input logic [15:0] cnt, input bit found);
    run_req(64'h3000, list, cnt, found, -1, 2'd0);
    chk(got_status == 2'd1, {tag, " status"}, 64'(got_status), 1);
    chk(got_index == 9'd0, {tag, " index"}, 64'(got_index), 0);
    chk(n_rd == 0, {tag, " no read"}, 64'(n_rd), 0);
    chk(done_cyc == acc_cyc + 1, "R10 reject timing", 64'(done_cyc), 64'(acc_cyc + 1));
  endtask

  task automatic t_normal(input logic [63:0] bus, input logic [63:0] list, input int cnt);
    logic [63:0] base, pbus;
    bit ok_r = 1, ok_a = 1, ok_d = 1;
    run_req(bus, list, 16'(cnt), 1, -1, 2'd0);
    base = list & ~64'h3;
    pbus = bus & ~64'hFFF;
    chk(n_rd == cnt && n_wr == cnt, "R5 entry count", 64'(n_wr), 64'(cnt));
    for (int i = 0; i < cnt && i < 600; i++) begin
      if (rd_log[i] != base + 64'(i) * 8) ok_r = 0;
      if (wa_log[i] != pbus + 64'(i) * 64'h1000) ok_a = 0;
      if (wd_log[i] != mem_word(base + 64'(i) * 8)) ok_d = 0;
    end
    chk(ok_r, "R4 read addresses", 64'(ok_r), 1);
    chk(ok_a, "R5 write addresses", 64'(ok_a), 1);
    chk(ok_d, "R5 write data", 64'(ok_d), 1);
    chk(got_status == 2'd0, "R7 success status", 64'(got_status), 0);
    chk(got_index == 9'(cnt - 1), "R8 success index", 64'(got_index), 64'(cnt - 1));
    chk(viol == 0, "R6 single outstanding read", 64'(viol), 0);
    chk(done_cyc == last_wr_cyc + 1, "R10 done timing", 64'(done_cyc), 64'(last_wr_cyc + 1));
  endtask

  task automatic t_fail(input int k, input logic [1:0] code);
    run_req(64'h0008_0ABC, 64'h0000_9000, 16'd6, 1, k, code);
    chk(got_status == code, "R7 error code", 64'(got_status), 64'(code));
    chk(n_wr == k + 1 && n_rd == k + 1, "R7 stop after failure", 64'(n_wr), 64'(k + 1));
    chk(got_index == 9'((k == 0) ? 0 : k - 1), "R8 failure index",
        64'(got_index), 64'((k == 0) ? 0 : k - 1));
    chk(done_cyc == last_wr_cyc + 1, "R10 failure timing", 64'(done_cyc), 64'(last_wr_cyc + 1));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++; nchecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reject("R1 count 513", 64'h0000_5000, 16'd513, 1);
    t_reject("R2 offset bits", 64'h0000_5008, 16'd4, 1);
    t_reject("R2 perm-only bits", 64'h0000_5003, 16'd4, 1);
    t_reject("R3 zero count", 64'h0000_5000, 16'd0, 1);
    t_reject("R3 table missing", 64'h0000_5000, 16'd3, 0);
    t_normal(64'h0004_0123, 64'h0000_7000, 5);
    t_normal(64'h0010_0000, 64'h0002_0000, 1);
    t_fail(3, 2'd2);
    t_fail(0, 2'd3);
    t_normal(64'h0200_0FFF, 64'h0003_0000, 512); // R1 upper boundary accepted
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule